// File: doc/BRIEF.md
# Framebuffer Mode Validator

This unit turns a set of display mode settings into the geometry that scanout logic needs to read a frame from video memory. It decodes the colour depth into a pixel format and a bytes-per-pixel count. It computes the line stride, the frame size and the byte address of the first visible pixel. It then decides whether the mode can be used at all.

A mode is usable only when all of the following hold: the display is enabled, the depth is supported, both visible dimensions are at least 64 pixels, and the frame fits inside the video memory. Downstream logic reads the geometry only while the valid flag is high. A one-cycle pulse tells it that a new usable mode differs from the last one it accepted, so it can rebuild its view of the frame.

All outputs are registered, so every output reflects the inputs sampled on the previous rising clock edge.

Top module: `fbm_validator`

## Requirements
- R1: When `enable_i` is low, `valid_o` is low.
- R2: A depth of 16 gives format code 1 (`fmt_o`) and 2 bytes per pixel.
- R3: A depth of 32 gives 4 bytes per pixel. The format code is 2 when `big_endian_i` is low and 3 when it is high.
- R4: Any depth other than 16 or 32 gives format code 0 and `valid_o` low.
- R5: The stride is the larger of `virt_width_i` and `xres_i`, multiplied by the bytes per pixel.
- R6: The frame size is the stride times `yres_i`. The start offset is `xoff_i` times the bytes per pixel plus `yoff_i` times the stride. Both are computed at 64-bit width.
- R7: `valid_o` is low when `xres_i` or `yres_i` is below 64. A value of exactly 64 is accepted.
- R8: `valid_o` is low when the start offset plus the frame size exceeds `vmem_bytes_i`. A frame that ends exactly at the memory size is accepted.
- R9: Every output reflects the inputs of the previous rising edge. During reset `valid_o`, `changed_o` and `fmt_o` are 0.
- R10: `changed_o` pulses for one cycle, together with `valid_o`, when a valid mode's format, bytes per pixel, width, height, stride, size or offset differs from the last valid mode. The reference before the first valid mode is all zeros. Invalid modes neither pulse nor replace the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Display enabled |
| bpp_i | input | 16 | Colour depth in bits per pixel |
| big_endian_i | input | 1 | Byte order of 32-bit pixels |
| xres_i | input | 16 | Visible width in pixels |
| yres_i | input | 16 | Visible height in pixels |
| virt_width_i | input | 16 | Virtual line width in pixels |
| xoff_i | input | 16 | Horizontal pan in pixels |
| yoff_i | input | 16 | Vertical pan in lines |
| vmem_bytes_i | input | 64 | Video memory size in bytes |
| valid_o | output | 1 | Mode usable |
| changed_o | output | 1 | New valid mode differs from the last |
| fmt_o | output | 2 | Format code: 0 none, 1 RGB565, 2 XRGB little, 3 XRGB big |
| bytes_o | output | 3 | Bytes per pixel |
| width_o | output | 16 | Visible width |
| height_o | output | 16 | Visible height |
| stride_o | output | 19 | Line stride in bytes |
| size_o | output | 64 | Frame size in bytes |
| offset_o | output | 64 | Start byte offset |

## Verification
The hardest case to reach is the overrun limit hit exactly: the frame's last byte falls on the final byte of video memory, and one byte less memory must flip the verdict. Random values almost never land there. The bench therefore builds directed 64x64 and panned modes and sets the memory size to the computed end address, and to that address minus one.

A second hard case is a mode that changes only in byte order. Such a mode must still raise the change pulse. The bench reaches it by repeating a valid 32-bit mode with the byte-order flag flipped, and it shows that repeating a mode unchanged gives no pulse.

The random part mixes small and large memory sizes, unsupported depths, and repeated vectors.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } fmt_e;

  localparam int unsigned BYTES_W = 3;
endpackage

// File: rtl/fbm_format_decode.sv
module fbm_format_decode
  import fbm_pkg::*;
#(
  parameter int unsigned BPP_W = 16
) (
  input  logic [BPP_W-1:0]   bpp_i,
  input  logic               big_endian_i,
  output fmt_e               fmt_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               ok_o
);
  always_comb begin
    fmt_o   = FMT_NONE;
    bytes_o = '0;
    ok_o    = 1'b0;
    if (bpp_i == BPP_W'(16)) begin
      fmt_o   = FMT_RGB565;
      bytes_o = BYTES_W'(2);
      ok_o    = 1'b1;
    end else if (bpp_i == BPP_W'(32)) begin
      fmt_o   = big_endian_i ? FMT_XRGB_BE : FMT_XRGB_LE;
      bytes_o = BYTES_W'(4);
      ok_o    = 1'b1;
    end
  end
endmodule

// File: rtl/fbm_geom_calc.sv
module fbm_geom_calc
  import fbm_pkg::*;
#(
  parameter int unsigned DIM_W  = 16,
  parameter int unsigned ADDR_W = 64
) (
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic [DIM_W-1:0]   xres_i,
  input  logic [DIM_W-1:0]   yres_i,
  input  logic [DIM_W-1:0]   virt_width_i,
  input  logic [DIM_W-1:0]   xoff_i,
  input  logic [DIM_W-1:0]   yoff_i,
  output logic [ADDR_W-1:0]  stride_o,
  output logic [ADDR_W-1:0]  size_o,
  output logic [ADDR_W-1:0]  offset_o
);
  logic [DIM_W-1:0] eff_w;

  // virtual width never narrower than the visible width
  assign eff_w    = (virt_width_i < xres_i) ? xres_i : virt_width_i;
  assign stride_o = ADDR_W'(eff_w) * ADDR_W'(bytes_i);
  assign size_o   = stride_o * ADDR_W'(yres_i);
  assign offset_o = ADDR_W'(xoff_i) * ADDR_W'(bytes_i) + ADDR_W'(yoff_i) * stride_o;
endmodule

// File: rtl/fbm_limit_check.sv
module fbm_limit_check #(
  parameter int unsigned DIM_W   = 16,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned MIN_DIM = 64
) (
  input  logic              enable_i,
  input  logic              fmt_ok_i,
  input  logic [DIM_W-1:0]  xres_i,
  input  logic [DIM_W-1:0]  yres_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] vmem_bytes_i,
  output logic              valid_o
);
  logic [ADDR_W:0] end_addr;
  logic            dims_ok, fits;

  // one extra bit so the sum cannot wrap
  assign end_addr = {1'b0, offset_i} + {1'b0, size_i};
  assign fits     = end_addr <= {1'b0, vmem_bytes_i};
  assign dims_ok  = (xres_i >= DIM_W'(MIN_DIM)) && (yres_i >= DIM_W'(MIN_DIM));
  assign valid_o  = enable_i && fmt_ok_i && dims_ok && fits;
endmodule

// File: rtl/fbm_validator.sv
module fbm_validator
  import fbm_pkg::*;
#(
  parameter int unsigned DIM_W   = 16,
  parameter int unsigned BPP_W   = 16,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned MIN_DIM = 64,
  localparam int unsigned STRIDE_W = DIM_W + BYTES_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [BPP_W-1:0]    bpp_i,
  input  logic                big_endian_i,
  input  logic [DIM_W-1:0]    xres_i,
  input  logic [DIM_W-1:0]    yres_i,
  input  logic [DIM_W-1:0]    virt_width_i,
  input  logic [DIM_W-1:0]    xoff_i,
  input  logic [DIM_W-1:0]    yoff_i,
  input  logic [ADDR_W-1:0]   vmem_bytes_i,
  output logic                valid_o,
  output logic                changed_o,
  output logic [1:0]          fmt_o,
  output logic [BYTES_W-1:0]  bytes_o,
  output logic [DIM_W-1:0]    width_o,
  output logic [DIM_W-1:0]    height_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [ADDR_W-1:0]   size_o,
  output logic [ADDR_W-1:0]   offset_o
);
  fmt_e               fmt_c;
  logic [BYTES_W-1:0] bytes_c;
  logic               fmt_ok_c, valid_c, differs_c;
  logic [ADDR_W-1:0]  stride_c, size_c, offset_c;

  fmt_e               last_fmt_q;
  logic [BYTES_W-1:0] last_bytes_q;
  logic [DIM_W-1:0]   last_w_q, last_h_q;
  logic [STRIDE_W-1:0] last_stride_q;
  logic [ADDR_W-1:0]  last_size_q, last_offset_q;

  fbm_format_decode #(.BPP_W(BPP_W)) i_fmt (
    .bpp_i        (bpp_i),
    .big_endian_i (big_endian_i),
    .fmt_o        (fmt_c),
    .bytes_o      (bytes_c),
    .ok_o         (fmt_ok_c)
  );

  fbm_geom_calc #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) i_geom (
    .bytes_i      (bytes_c),
    .xres_i       (xres_i),
    .yres_i       (yres_i),
    .virt_width_i (virt_width_i),
    .xoff_i       (xoff_i),
    .yoff_i       (yoff_i),
    .stride_o     (stride_c),
    .size_o       (size_c),
    .offset_o     (offset_c)
  );

  fbm_limit_check #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .MIN_DIM(MIN_DIM)) i_lim (
    .enable_i     (enable_i),
    .fmt_ok_i     (fmt_ok_c),
    .xres_i       (xres_i),
    .yres_i       (yres_i),
    .size_i       (size_c),
    .offset_i     (offset_c),
    .vmem_bytes_i (vmem_bytes_i),
    .valid_o      (valid_c)
  );

  assign differs_c = (fmt_c != last_fmt_q) || (bytes_c != last_bytes_q) ||
                     (xres_i != last_w_q) || (yres_i != last_h_q) ||
                     (stride_c[STRIDE_W-1:0] != last_stride_q) ||
                     (size_c != last_size_q) || (offset_c != last_offset_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      changed_o <= 1'b0;
      fmt_o     <= FMT_NONE;
      bytes_o   <= '0;
      width_o   <= '0;
      height_o  <= '0;
      stride_o  <= '0;
      size_o    <= '0;
      offset_o  <= '0;
    end else begin
      valid_o   <= valid_c;
      changed_o <= valid_c && differs_c;
      fmt_o     <= fmt_c;
      bytes_o   <= bytes_c;
      width_o   <= xres_i;
      height_o  <= yres_i;
      stride_o  <= stride_c[STRIDE_W-1:0];
      size_o    <= size_c;
      offset_o  <= offset_c;
    end
  end

  // reference copy of the last accepted mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_fmt_q    <= FMT_NONE;
      last_bytes_q  <= '0;
      last_w_q      <= '0;
      last_h_q      <= '0;
      last_stride_q <= '0;
      last_size_q   <= '0;
      last_offset_q <= '0;
    end else if (valid_c) begin
      last_fmt_q    <= fmt_c;
      last_bytes_q  <= bytes_c;
      last_w_q      <= xres_i;
      last_h_q      <= yres_i;
      last_stride_q <= stride_c[STRIDE_W-1:0];
      last_size_q   <= size_c;
      last_offset_q <= offset_c;
    end
  end
endmodule

// File: rtl/fbm_checker.sv
module fbm_checker #(
  parameter int unsigned DIM_W   = 16,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned MIN_DIM = 64,
  localparam int unsigned STRIDE_W = DIM_W + 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic [ADDR_W-1:0]   vmem_bytes_i,
  input logic                valid_o,
  input logic                changed_o,
  input logic [1:0]          fmt_o,
  input logic [2:0]          bytes_o,
  input logic [DIM_W-1:0]    width_o,
  input logic [DIM_W-1:0]    height_o,
  input logic [STRIDE_W-1:0] stride_o,
  input logic [ADDR_W-1:0]   size_o,
  input logic [ADDR_W-1:0]   offset_o
);
  // R1
  disabled_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !valid_o);

  // R7
  min_dim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (width_o >= DIM_W'(MIN_DIM)) && (height_o >= DIM_W'(MIN_DIM)));

  // R8
  fits_vmem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, offset_o} + {1'b0, size_o}) <= {1'b0, $past(vmem_bytes_i)});

  // R2
  rgb565_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fmt_o == 2'd1) |-> bytes_o == 3'd2);

  // R5
  stride_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> stride_o >= STRIDE_W'(width_o) * STRIDE_W'(bytes_o));

  // R10
  changed_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> valid_o);
endmodule

bind fbm_validator fbm_checker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .MIN_DIM(MIN_DIM)) i_fbm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .vmem_bytes_i (vmem_bytes_i),
  .valid_o      (valid_o),
  .changed_o    (changed_o),
  .fmt_o        (fmt_o),
  .bytes_o      (bytes_o),
  .width_o      (width_o),
  .height_o     (height_o),
  .stride_o     (stride_o),
  .size_o       (size_o),
  .offset_o     (offset_o)
);

// File: tb/test_fbm_validator.sv
`timescale 1ns/1ps
module test_fbm_validator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i, be_i;
  logic [15:0] bpp_i, xres_i, yres_i, virt_i, xoff_i, yoff_i;
  logic [63:0] vmem_i;
  logic        valid_o, changed_o;
  logic [1:0]  fmt_o;
  logic [2:0]  bytes_o;
  logic [15:0] width_o, height_o;
  logic [18:0] stride_o;
  logic [63:0] size_o, offset_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference copy of the last valid mode, kept by the bench
  longint l_fmt = 0, l_by = 0, l_w = 0, l_h = 0, l_st = 0, l_sz = 0, l_off = 0;

  always #5 clk = ~clk;

  fbm_validator i_fbm_validator (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en_i), .bpp_i(bpp_i), .big_endian_i(be_i),
    .xres_i(xres_i), .yres_i(yres_i), .virt_width_i(virt_i), .xoff_i(xoff_i),
    .yoff_i(yoff_i), .vmem_bytes_i(vmem_i), .valid_o(valid_o), .changed_o(changed_o),
    .fmt_o(fmt_o), .bytes_o(bytes_o), .width_o(width_o), .height_o(height_o),
    .stride_o(stride_o), .size_o(size_o), .offset_o(offset_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input bit en, input int bpp, input bit be, input int xr, input int yr,
                       input int vw, input int xo, input int yo, input longint vm);
    longint e_fmt, e_by, e_ew, e_st, e_sz, e_off;
    bit e_val, e_ch;
    string why;
    @(negedge clk);
    en_i = en; bpp_i = 16'(bpp); be_i = be; xres_i = 16'(xr); yres_i = 16'(yr);
    virt_i = 16'(vw); xoff_i = 16'(xo); yoff_i = 16'(yo); vmem_i = 64'(vm);
    if (bpp == 16) begin e_fmt = 1; e_by = 2; end
    else if (bpp == 32) begin e_fmt = be ? 3 : 2; e_by = 4; end
    else begin e_fmt = 0; e_by = 0; end
    e_ew  = (vw < xr) ? xr : vw;
    e_st  = e_ew * e_by;
    e_sz  = e_st * yr;
    e_off = xo * e_by + yo * e_st;
    e_val = 1;
    why = "R9";
    if (!en) begin e_val = 0; why = "R1"; end
    else if (e_by == 0) begin e_val = 0; why = "R4"; end
    else if (xr < 64 || yr < 64) begin e_val = 0; why = "R7"; end
    else if (e_off + e_sz > vm) begin e_val = 0; why = "R8"; end
    else why = "R8";
    e_ch = 0;
    if (e_val && (e_fmt != l_fmt || e_by != l_by || xr != l_w || yr != l_h ||
                  e_st != l_st || e_sz != l_sz || e_off != l_off)) e_ch = 1;
    if (e_val) begin
      l_fmt = e_fmt; l_by = e_by; l_w = xr; l_h = yr; l_st = e_st; l_sz = e_sz; l_off = e_off;
    end
    @(negedge clk);
    chk(valid_o == e_val, why, longint'(valid_o), longint'(e_val));
    chk(changed_o == e_ch, "R10", longint'(changed_o), longint'(e_ch));
    chk(fmt_o == 2'(e_fmt), (bpp == 32) ? "R3" : (bpp == 16) ? "R2" : "R4",
        longint'(fmt_o), e_fmt);
    if (e_val) begin
      chk(bytes_o == 3'(e_by), (bpp == 32) ? "R3" : "R2", longint'(bytes_o), e_by);
      chk(width_o == 16'(xr) && height_o == 16'(yr), "R9", longint'(width_o), longint'(xr));
      chk(longint'(stride_o) == e_st, "R5", longint'(stride_o), e_st);
      chk(longint'(size_o) == e_sz, "R6", longint'(size_o), e_sz);
      chk(longint'(offset_o) == e_off, "R6", longint'(offset_o), e_off);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    en_i = 0; be_i = 0; bpp_i = 0; xres_i = 0; yres_i = 0; virt_i = 0;
    xoff_i = 0; yoff_i = 0; vmem_i = 0;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!valid_o && !changed_o && fmt_o == 2'd0, "R9", longint'(valid_o), 0);
    rst_n = 1'b1;
    // R1 disabled
    apply(0, 32, 0, 640, 480, 0, 0, 0, 64'h100_0000);
    // R2 / R5 clamp of virtual width
    apply(1, 16, 0, 640, 480, 100, 0, 0, 64'h100_0000);
    // R10 repeat gives no pulse
    apply(1, 16, 0, 640, 480, 100, 0, 0, 64'h100_0000);
    // R3 wider virtual width, then byte order flip alone
    apply(1, 32, 0, 640, 480, 1024, 3, 5, 64'h100_0000);
    apply(1, 32, 1, 640, 480, 1024, 3, 5, 64'h100_0000);
    // R4 unsupported depth, reference unchanged afterwards
    apply(1, 24, 0, 640, 480, 0, 0, 0, 64'h100_0000);
    apply(1, 32, 1, 640, 480, 1024, 3, 5, 64'h100_0000);
    // R7 limits
    apply(1, 32, 0, 63, 100, 0, 0, 0, 64'h100_0000);
    apply(1, 32, 0, 100, 63, 0, 0, 0, 64'h100_0000);
    apply(1, 32, 0, 64, 64, 0, 0, 0, 64'h100_0000);
    // R8 exact fit and one byte short
    apply(1, 32, 0, 64, 64, 0, 0, 0, 64'd16384);
    apply(1, 32, 0, 64, 64, 0, 0, 0, 64'd16383);
    apply(1, 16, 0, 64, 64, 80, 7, 9, 64'd10240 + 64'd14 + 64'd9 * 64'd160 - 64'd0 - 64'd1440 + 64'd1440);
    apply(1, 16, 0, 64, 64, 80, 7, 9, 64'd10240 + 64'd14 + 64'd1440 - 64'd1);
    // R6 large pan at 64-bit width
    apply(1, 32, 0, 65535, 65535, 65535, 65535, 65535, 64'hFFFF_FFFF_FFFF);
    for (int i = 0; i < 400; i++) begin
      int r, bpp, xr, yr, vw, xo, yo;
      longint vm;
      if ((($urandom % 5) == 0) && i > 0) begin
        apply(en_i, int'(bpp_i), be_i, int'(xres_i), int'(yres_i), int'(virt_i),
              int'(xoff_i), int'(yoff_i), longint'(vmem_i));
      end else begin
        r = $urandom % 6;
        bpp = (r < 2) ? 16 : (r < 4) ? 32 : (r == 4) ? 24 : int'($urandom % 64);
        xr = 40 + int'($urandom % 1060);
        yr = 40 + int'($urandom % 760);
        vw = int'($urandom % 1200);
        xo = int'($urandom % 300);
        yo = int'($urandom % 300);
        r = $urandom % 3;
        vm = (r == 0) ? 64'h8_0000 : (r == 1) ? 64'h40_0000 : 64'h100_0000;
        apply(($urandom % 8) != 0, bpp, 1'($urandom), xr, yr, vw, xo, yo, vm);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule